// File: doc/BRIEF.md
# Asynchronous Serial Transmit Controller

This block turns characters written into a one-entry holding buffer into asynchronous serial frames on a single line. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, an optional parity or address-marker bit, and one, one and a half or two high stop bits. A state machine sequences the frame. It has a disabled state that is separate from idle, and it can also hold the line in a break condition.

Timing comes from an external tick, `halfTick`, that pulses once per half bit period. One bit period is therefore two ticks, which allows 1.5 stop bits. Frame sequencing and break handling advance only on a tick. The enable, disable and reset commands act on the clock edge at which they arrive. Software or a DMA engine watches `txReady` and writes through a single-cycle strobe. The line, the parity mode and the stop mode are taken live, so they must be held steady while a frame is on the line.

Top module: `async_tx_ctrl`

## Requirements
- R1: Hardware reset (`rstN` low) puts the transmitter in the disabled state, with `txd` = 1 and `txReady` = 0. A pulse on `chanRst`, `txRst` or `cmdDisable` at a clock edge has the same effect and also discards any buffered character. This applies in any state and cuts off any frame in progress.
- R2: `cmdEnable` moves a disabled transmitter to idle at the next clock edge, after which `txReady` = 1 and `txd` stays 1. A `wrStrobe` seen while disabled is ignored and leaves nothing to send.
- R3: `txReady` is 1 exactly when the transmitter is enabled and the buffer is empty. An accepted write clears it at the next edge. It returns to 1 at the tick where the character moves into the shifter, which is the first tick of the start bit. A write while `txReady` = 0 is ignored.
- R4: In idle, the first `halfTick` that finds a buffered character and no break request starts a frame. The start bit holds `txd` = 0 for two ticks.
- R5: The data bits are sent least significant bit first, two ticks each. The bit count is 5 + `charLen`, so 00 gives 5 bits and 11 gives 8.
- R6: `parMode` selects the bit after the data. 00 sends no bit. 01 sends an address-marker bit whose value is `mpBit` sampled with the write. 10 sends even parity and 11 sends odd parity, both computed over the transmitted data bits only.
- R7: `stopMode` sets the high stop time. 00 gives 2 ticks, 01 gives 3 ticks, and 10 or 11 give 4 ticks. The transmitter then returns to idle.
- R8: A `breakReq` seen at a tick in idle drives `txd` = 0 and holds it until a tick with `breakReq` = 0. A frame in progress is finished first. A break takes priority over a buffered character.
- R9: After a break ends, `txd` is 1 for exactly two ticks before the transmitter is idle again and may start a frame.
- R10: Without a tick or a reset/disable command at a clock edge, `txd` does not change at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanRst | input | 1 | Channel reset strobe |
| txRst | input | 1 | Transmitter reset strobe |
| cmdEnable | input | 1 | Enable command strobe |
| cmdDisable | input | 1 | Disable command strobe |
| halfTick | input | 1 | Half-bit-period tick |
| wrStrobe | input | 1 | Transmit buffer write strobe |
| wrData | input | DATA_W | Character to transmit |
| mpBit | input | 1 | Address-marker bit value, sampled with the write |
| charLen | input | 2 | Data bit count minus 5 |
| parMode | input | 2 | 00 none, 01 marker, 10 even, 11 odd |
| stopMode | input | 2 | 00 one, 01 one and a half, 1x two stop bits |
| breakReq | input | 1 | Break request level |
| txReady | output | 1 | Buffer empty and transmitter enabled |
| txd | output | 1 | Serial output, idle high |

## Verification
The hardest situation to reach is two events landing in the same tick. One is a break request arriving while a frame is mid-flight and a second character is already buffered. The other is a reset command cutting a frame at an arbitrary bit. The stimulus raises `breakReq` a fixed number of cycles into a frame and writes a character during the break, so the break, the mark period and the held-over frame follow one another. Separately, it fires `cmdDisable`, `chanRst` and `txRst` at cycles placed inside the data bits. It also stops the tick stream mid-frame, so that the line must stay frozen.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [2:0] {
    ST_DIS, ST_IDLE, ST_START, ST_CHAR, ST_PAR, ST_STOP, ST_BRK, ST_MARK
  } txState_e;

  typedef enum logic [1:0] {
    LN_MARK, LN_SPACE, LN_DATA, LN_PAR
  } lineSel_e;

  typedef struct packed {
    logic     load;     // buffer -> shifter
    logic     shift;    // advance one data bit
    logic     flush;    // drop buffered character
    logic     enabled;  // not in disabled state
    lineSel_e lineSel;  // output source
  } txStrobe_t;
endpackage

// File: rtl/atx_ctrl.sv
module atx_ctrl
  import atx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanRst,
  input  logic       txRst,
  input  logic       cmdEnable,
  input  logic       cmdDisable,
  input  logic       halfTick,
  input  logic       breakReq,
  input  logic       bufFull,
  input  logic [1:0] charLen,
  input  logic [1:0] parMode,
  input  logic [1:0] stopMode,
  output txStrobe_t  strb,
  output txState_e   stateOut
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int MIN_LAST = DATA_W - 4;

  txState_e         state;
  logic [1:0]       cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [1:0]       stopLast;
  logic             forceDis;
  logic             bitEnd;

  always_comb begin
    forceDis = chanRst | txRst | cmdDisable;
    lastIdx  = IDX_W'(MIN_LAST) + IDX_W'(charLen);
    case (stopMode)
      2'b00:   stopLast = 2'd1;
      2'b01:   stopLast = 2'd2;
      default: stopLast = 2'd3;
    endcase
    bitEnd = halfTick && (cnt == 2'd1);

    strb.enabled = (state != ST_DIS);
    strb.flush   = forceDis;
    strb.load    = !forceDis && (state == ST_IDLE) && halfTick && !breakReq && bufFull;
    strb.shift   = !forceDis && (state == ST_CHAR) && bitEnd;
    case (state)
      ST_START, ST_BRK: strb.lineSel = LN_SPACE;
      ST_CHAR:          strb.lineSel = LN_DATA;
      ST_PAR:           strb.lineSel = LN_PAR;
      default:          strb.lineSel = LN_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_DIS;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (forceDis) begin
      state  <= ST_DIS;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_DIS:  if (cmdEnable) state <= ST_IDLE;
        ST_IDLE: if (halfTick) begin
          if (breakReq) state <= ST_BRK;
          else if (bufFull) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: if (halfTick) begin
          if (cnt == 2'd1) begin
            state  <= ST_CHAR;
            cnt    <= '0;
            bitIdx <= '0;
          end else cnt <= cnt + 2'd1;
        end
        ST_CHAR: if (halfTick) begin
          if (cnt == 2'd1) begin
            cnt <= '0;
            if (bitIdx == lastIdx) state <= (parMode != 2'b00) ? ST_PAR : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else cnt <= cnt + 2'd1;
        end
        ST_PAR: if (halfTick) begin
          if (cnt == 2'd1) begin
            state <= ST_STOP;
            cnt   <= '0;
          end else cnt <= cnt + 2'd1;
        end
        ST_STOP: if (halfTick) begin
          if (cnt == stopLast) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 2'd1;
        end
        ST_BRK: if (halfTick && !breakReq) begin
          state <= ST_MARK;
          cnt   <= '0;
        end
        ST_MARK: if (halfTick) begin
          if (cnt == 2'd1) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 2'd1;
        end
        default: state <= ST_DIS;
      endcase
    end
  end

  assign stateOut = state;
endmodule

// File: rtl/atx_dpath.sv
module atx_dpath
  import atx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mpBit,
  input  logic [1:0]        parMode,
  output logic              bufFull,
  output logic              txReady,
  output logic              txd
);
  logic [DATA_W-1:0] bufData;
  logic              bufMp;
  logic [DATA_W-1:0] shReg;
  logic              mpHold;
  logic              parAcc;
  logic              parBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
      bufMp   <= 1'b0;
      bufFull <= 1'b0;
      shReg   <= '0;
      mpHold  <= 1'b0;
      parAcc  <= 1'b0;
    end else begin
      if (strb.flush) begin
        bufFull <= 1'b0;
      end else if (strb.load) begin
        shReg   <= bufData;
        mpHold  <= bufMp;
        parAcc  <= 1'b0;
        bufFull <= 1'b0;
      end else if (wrStrobe && strb.enabled && !bufFull) begin
        bufData <= wrData;
        bufMp   <= mpBit;
        bufFull <= 1'b1;
      end
      if (strb.shift) begin
        shReg  <= shReg >> 1;
        parAcc <= parAcc ^ shReg[0];
      end
    end
  end

  always_comb begin
    case (parMode)
      2'b01:   parBit = mpHold;
      2'b10:   parBit = parAcc;
      2'b11:   parBit = ~parAcc;
      default: parBit = 1'b1;
    endcase
    case (strb.lineSel)
      LN_SPACE: txd = 1'b0;
      LN_DATA:  txd = shReg[0];
      LN_PAR:   txd = parBit;
      default:  txd = 1'b1;
    endcase
    txReady = strb.enabled && !bufFull;
  end
endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import atx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanRst,
  input  logic              txRst,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              halfTick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mpBit,
  input  logic [1:0]        charLen,
  input  logic [1:0]        parMode,
  input  logic [1:0]        stopMode,
  input  logic              breakReq,
  output logic              txReady,
  output logic              txd
);
  txStrobe_t strb;
  txState_e  curState;
  logic      bufFull;

  atx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanRst(chanRst), .txRst(txRst),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .halfTick(halfTick),
    .breakReq(breakReq), .bufFull(bufFull), .charLen(charLen),
    .parMode(parMode), .stopMode(stopMode), .strb(strb), .stateOut(curState)
  );

  atx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrStrobe(wrStrobe),
    .wrData(wrData), .mpBit(mpBit), .parMode(parMode),
    .bufFull(bufFull), .txReady(txReady), .txd(txd)
  );
endmodule

// File: rtl/atx_chk.sv
module atx_chk
  import atx_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     chanRst,
  input logic     txRst,
  input logic     cmdDisable,
  input logic     wrStrobe,
  input logic     halfTick,
  input logic     breakReq,
  input logic     txReady,
  input logic     txd,
  input txState_e st
);
  logic noForce;
  assign noForce = !(chanRst || txRst || cmdDisable);

  AST_FORCE_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    !noForce |=> (txd && !txReady)); // R1

  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && txReady && noForce) |=> !txReady); // R3

  AST_LOAD_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && halfTick && !breakReq && !txReady && noForce)
      |=> (st == ST_START && txReady && !txd)); // R4

  AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_BRK && breakReq && noForce) |=> (st == ST_BRK && !txd)); // R8

  AST_MARK_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_BRK && halfTick && !breakReq && noForce) |=> (st == ST_MARK && txd)); // R9

  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!halfTick && noForce) |=> $stable(txd)); // R10
endmodule

bind async_tx_ctrl atx_chk u_chk (
  .clk(clk), .rstN(rstN), .chanRst(chanRst), .txRst(txRst),
  .cmdDisable(cmdDisable), .wrStrobe(wrStrobe), .halfTick(halfTick),
  .breakReq(breakReq), .txReady(txReady), .txd(txd), .st(curState)
);

// File: tb/sim_async_tx_ctrl.sv
module sim_async_tx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanRst = 0, txRst = 0, cmdEnable = 0, cmdDisable = 0;
  logic halfTick = 0, wrStrobe = 0, mpBit = 0, breakReq = 0;
  logic [7:0] wrData = '0;
  logic [1:0] charLen = 2'b11, parMode = 2'b00, stopMode = 2'b00;
  logic txReady, txd;

  int checks = 0, failures = 0, cycles = 0;
  string curReq = "R1";
  bit tickEn = 1'b1;
  int tickPh = 0;
  bit done = 1'b0;

  // reference model state
  bit mDis, mFull, mBufMp, oldFull;
  logic [7:0] mBuf;
  bit mQ[$];
  int mBrk, mMark;

  async_tx_ctrl u0 (
    .clk(clk), .rstN(rstN), .chanRst(chanRst), .txRst(txRst),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .halfTick(halfTick),
    .wrStrobe(wrStrobe), .wrData(wrData), .mpBit(mpBit), .charLen(charLen),
    .parMode(parMode), .stopMode(stopMode), .breakReq(breakReq),
    .txReady(txReady), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void buildFrame();
    int len = 5 + int'(charLen);
    bit ones = 1'b0;
    int stopSlots = (stopMode == 2'b00) ? 2 : (stopMode == 2'b01) ? 3 : 4;
    mQ.push_back(1'b0); mQ.push_back(1'b0);
    for (int i = 0; i < len; i++) begin
      mQ.push_back(mBuf[i]); mQ.push_back(mBuf[i]);
      ones ^= mBuf[i];
    end
    if (parMode != 2'b00) begin
      bit pb = (parMode == 2'b01) ? mBufMp : (parMode == 2'b10) ? ones : !ones;
      mQ.push_back(pb); mQ.push_back(pb);
    end
    for (int i = 0; i < stopSlots; i++) mQ.push_back(1'b1);
  endfunction

  function automatic bit modelTxd();
    if (mDis) return 1'b1;
    if (mBrk == 1) return 1'b0;
    if (mBrk == 2) return 1'b1;
    if (mQ.size() > 0) return mQ[0];
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDis = 1; mFull = 0; mBrk = 0; mMark = 0; mQ.delete();
    end else if (chanRst || txRst || cmdDisable) begin
      mDis = 1; mFull = 0; mBrk = 0; mQ.delete();
    end else if (mDis) begin
      if (cmdEnable) mDis = 0;
    end else begin
      oldFull = mFull;
      if (halfTick) begin
        if (mBrk == 1) begin
          if (!breakReq) begin mBrk = 2; mMark = 2; end
        end else if (mBrk == 2) begin
          mMark--;
          if (mMark == 0) mBrk = 0;
        end else if (mQ.size() > 0) begin
          void'(mQ.pop_front());
        end else if (breakReq) begin
          mBrk = 1;
        end else if (mFull) begin
          buildFrame();
          mFull = 0;
        end
      end
      if (wrStrobe && !oldFull) begin
        mFull = 1; mBuf = wrData; mBufMp = mpBit;
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // tick generator, per-cycle comparison and watchdog
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (txd !== modelTxd() || txReady !== (!mDis && !mFull)) begin
        failures++;
        $display("FAIL %s cycle %0d: txd=%b ready=%b expected txd=%b ready=%b",
                 curReq, cycles, txd, txReady, modelTxd(), !mDis && !mFull);
      end
    end
    if (!tickEn) halfTick = 1'b0;
    else begin
      tickPh = (tickPh + 1) % 3;
      halfTick = (tickPh == 0);
    end
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d (expected completion)", cycles);
      report();
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic sendChar(logic [7:0] d, logic mp);
    while (!txReady) @(negedge clk);
    wrData = d; mpBit = mp; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitDone();
    while (mQ.size() != 0 || mFull || mBrk != 0) @(negedge clk);
    cyc(3);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset ready", txReady, 1'b0);
    rstN = 1'b1;
    cyc(2);
    chk("R1 disabled after reset ready", txReady, 1'b0);

    curReq = "R2";
    wrData = 8'h3C; pulse(wrStrobe);           // ignored while disabled
    chk("R2 write while disabled ready", txReady, 1'b0);
    pulse(cmdEnable);
    chk("R2 ready after enable", txReady, 1'b1);
    cyc(20);
    chk("R2 no frame from ignored write", txd, 1'b1);

    curReq = "R5"; charLen = 2'b11; parMode = 2'b00; stopMode = 2'b00;
    sendChar(8'hA5, 0); waitDone();
    sendChar(8'h01, 0); waitDone();

    curReq = "R6"; charLen = 2'b10; parMode = 2'b10;
    sendChar(8'h53, 0); waitDone();
    charLen = 2'b00; parMode = 2'b11;
    sendChar(8'hFB, 0); waitDone();
    charLen = 2'b11; parMode = 2'b01;
    sendChar(8'h80, 1); waitDone();
    sendChar(8'h7F, 0); waitDone();

    curReq = "R7"; parMode = 2'b10;
    for (int s = 1; s < 4; s++) begin
      stopMode = 2'(s);
      sendChar(8'hC3, 0); waitDone();
    end

    curReq = "R3"; stopMode = 2'b00; parMode = 2'b00;
    sendChar(8'h11, 0);
    chk("R3 ready clears after write", txReady, 1'b0);
    wrData = 8'hEE; pulse(wrStrobe);            // ignored, buffer full
    sendChar(8'h22, 0);
    sendChar(8'h44, 0);
    waitDone();

    curReq = "R8";
    sendChar(8'h96, 0);
    cyc(10);
    breakReq = 1'b1;
    cyc(30);
    sendChar(8'h5A, 0);                         // held during break
    cyc(60);
    chk("R8 line low during break", txd, 1'b0);
    curReq = "R9";
    breakReq = 1'b0;
    waitDone();

    curReq = "R10"; charLen = 2'b11;
    sendChar(8'hB4, 0);
    cyc(12); tickEn = 1'b0; cyc(25); tickEn = 1'b1;
    waitDone();

    curReq = "R1";
    sendChar(8'h0F, 0); sendChar(8'hF0, 0);
    cyc(14); pulse(cmdDisable);
    chk("R1 disable txd", txd, 1'b1);
    chk("R1 disable ready", txReady, 1'b0);
    cyc(10); pulse(cmdEnable); cyc(30);
    chk("R1 pending discarded", txd, 1'b1);
    sendChar(8'h69, 0); sendChar(8'h96, 0);
    cyc(17); pulse(chanRst);
    chk("R1 chanRst ready", txReady, 1'b0);
    pulse(cmdEnable);
    sendChar(8'h55, 0);
    cyc(20); pulse(txRst);
    chk("R1 txRst txd", txd, 1'b1);
    pulse(cmdEnable);
    curReq = "R4";
    sendChar(8'hAA, 0); waitDone();

    report();
  end
endmodule